// File: doc/BRIEF.md
# Vector Half-Widening Extend Unit

This unit executes one class of scalable-vector instruction: it takes half of the narrow elements in a source vector register, widens each one to twice its width, and writes them to the destination lanes. The caller presents a 32-bit instruction word and the contents of the source register, whose width `VL_BITS` is set by a parameter and is a multiple of 128. One cycle later the unit returns one of two things. The first is the destination register index with the widened vector and a valid flag. The second is an illegal flag with an all-zero result.

Three fields of the word steer the operation. A two-bit size field picks the destination lane width. Bit 16 picks whether the lower or the upper half of the source elements is read. Bit 17 picks sign or zero extension. Destination lane `e` always takes element `e` of the chosen half. The unit has no predication and no flags. The register file, and any change of vector length while running, belong to the surrounding pipeline.

The control is a three-state output machine. `ST_IDLE` means nothing was issued in the previous cycle. `ST_DONE` means a legal word was issued. `ST_TRAP` means an illegal word was issued. The next state depends only on the current inputs. If `in_valid` is low, the machine goes to `ST_IDLE`. If `in_valid` is high and the word decodes as legal, it goes to `ST_DONE`. If `in_valid` is high and the word is illegal, it goes to `ST_TRAP`. Reset forces `ST_IDLE`.

Top module: `vwu_unit`

## Requirements
- R1: While synchronous active-high `rst` is high, and in the cycle after it is released with `in_valid` low, `out_valid`, `out_illegal`, `out_rd` and `out_vec` are all zero.
- R2: A word presented with `in_valid` high at a clock edge produces its result on the outputs right after that edge (one-cycle latency). If `in_valid` was low at an edge, both `out_valid` and `out_illegal` are low after it.
- R3: A word is recognised only when `(instr & 32'hFF3CFC00) == 32'h05303800`. Any other word with `in_valid` high gives `out_illegal` = 1, `out_valid` = 0 and a zero `out_vec`.
- R4: Size field `instr[23:22]` = 00 is reserved. A recognised word with that size gives `out_illegal` = 1, `out_valid` = 0 and a zero `out_vec`.
- R5: Size 01 gives 16-bit lanes from bytes, 10 gives 32-bit lanes from halfwords, and 11 gives 64-bit lanes from words. The result has `VL_BITS`/lane-width lanes, and every lane is written.
- R6: With `instr[16]` = 0 (low half), destination lane `e` holds source element `e`, where the source is viewed as elements of half the lane width.
- R7: With `instr[16]` = 1 (high half), destination lane `e` holds source element `e + VL_BITS/lane-width`.
- R8: With `instr[17]` = 0, the upper half of each lane repeats the source element's top bit (sign extension). With `instr[17]` = 1, the upper half is zero.
- R9: On a legal result, `out_rd` equals `instr[4:0]`. The source-index field `instr[9:5]` has no effect on `out_vec`.
- R10: `out_valid` and `out_illegal` are never high together, and `out_vec` and `out_rd` are zero whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is issued this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | VL_BITS | Source vector register contents |
| out_valid | output | 1 | Registered: legal result present |
| out_illegal | output | 1 | Registered: issued word was illegal |
| out_rd | output | 5 | Registered destination register index |
| out_vec | output | VL_BITS | Registered widened result |

## Verification
The hardest case to reach is the high-half read with sign extension. Here a wrong lane offset or a sign bit taken from the wrong element stays hidden unless the upper source half differs from the lower half and has its top bits set. The stimulus therefore fills the two halves with different random data, and also uses uniform 0x80 and 0xFF byte patterns. It sends back-to-back words that change the size, half and sign bits every cycle, so that a result left over from the previous word would show. Illegal words flip single fixed opcode bits, or use size 00, in between legal words. This checks that the zero result and the cleared valid flag appear in exactly the following cycle.

// File: rtl/vwu_pkg.sv
package vwu_pkg;

    localparam logic [31:0] OPC_MASK  = 32'hFF3C_FC00;
    localparam logic [31:0] OPC_MATCH = 32'h0530_3800;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_TRAP = 2'd2
    } vwu_state_e;

    typedef enum logic [1:0] {
        SZ_RSVD = 2'b00,
        SZ_B2H  = 2'b01,
        SZ_H2S  = 2'b10,
        SZ_S2D  = 2'b11
    } vwu_size_e;

    typedef struct packed {
        logic      legal;
        vwu_size_e size;
        logic      upper;
        logic      zext;
        logic [4:0] rd;
    } vwu_dec_t;

endpackage

// File: rtl/vwu_decode.sv
module vwu_decode
    import vwu_pkg::*;
(
    input  logic [31:0] instr,
    output vwu_dec_t    dec
);
    logic opc_hit;
    logic size_ok;

    always_comb begin
        opc_hit   = ((instr & OPC_MASK) == OPC_MATCH);
        size_ok   = (instr[23:22] != SZ_RSVD);
        dec.legal = opc_hit && size_ok;
        dec.size  = vwu_size_e'(instr[23:22]);
        dec.upper = instr[16];
        dec.zext  = instr[17];
        dec.rd    = instr[4:0];
    end

    // R4: a legal decode never carries the reserved size
    always_comb begin
        assert_no_rsvd_R4: assert (!dec.legal || instr[23:22] != 2'b00);
    end

endmodule

// File: rtl/vwu_lane_group.sv
module vwu_lane_group #(
    parameter int VL_BITS = 256,
    parameter int DST_W   = 16
) (
    input  logic [VL_BITS-1:0] src,
    input  logic               upper,
    input  logic               zext,
    output logic [VL_BITS-1:0] dst
);
    localparam int HALF_W = DST_W / 2;
    localparam int LANES  = VL_BITS / DST_W;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        logic [HALF_W-1:0] lo_elem;
        logic [HALF_W-1:0] hi_elem;
        logic [HALF_W-1:0] pick;
        logic              fill;

        assign lo_elem = src[e*HALF_W +: HALF_W];
        assign hi_elem = src[(e+LANES)*HALF_W +: HALF_W];
        assign pick    = upper ? hi_elem : lo_elem;
        assign fill    = zext ? 1'b0 : pick[HALF_W-1];
        assign dst[e*DST_W +: DST_W] = {{HALF_W{fill}}, pick};
    end

endmodule

// File: rtl/vwu_widen.sv
module vwu_widen
    import vwu_pkg::*;
#(
    parameter int VL_BITS = 256
) (
    input  logic [VL_BITS-1:0] src,
    input  vwu_size_e          size,
    input  logic               upper,
    input  logic               zext,
    output logic [VL_BITS-1:0] result
);
    localparam int N_WIDTHS = 3;

    logic [VL_BITS-1:0] by_width [N_WIDTHS];

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        vwu_lane_group #(
            .VL_BITS (VL_BITS),
            .DST_W   (16 << g)
        ) u_group (
            .src   (src),
            .upper (upper),
            .zext  (zext),
            .dst   (by_width[g])
        );
    end

    always_comb begin
        unique case (size)
            SZ_B2H:  result = by_width[0];
            SZ_H2S:  result = by_width[1];
            SZ_S2D:  result = by_width[2];
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/vwu_unit.sv
module vwu_unit
    import vwu_pkg::*;
#(
    parameter int VL_BITS = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic [VL_BITS-1:0] src_vec,
    output logic               out_valid,
    output logic               out_illegal,
    output logic [4:0]         out_rd,
    output logic [VL_BITS-1:0] out_vec
);
    initial begin
        assert_vl_multiple: assert (VL_BITS % 128 == 0 && VL_BITS >= 128);
    end

    vwu_dec_t           dec;
    logic [VL_BITS-1:0] wide;
    vwu_state_e         state, state_nx;

    vwu_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    vwu_widen #(.VL_BITS(VL_BITS)) u_widen (
        .src    (src_vec),
        .size   (dec.size),
        .upper  (dec.upper),
        .zext   (dec.zext),
        .result (wide)
    );

    // next-state: every state moves on the issue of this cycle
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_DONE, ST_TRAP: begin
                if (!in_valid)      state_nx = ST_IDLE;
                else if (dec.legal) state_nx = ST_DONE;
                else                state_nx = ST_TRAP;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // registered datapath outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vec <= '0;
            out_rd  <= '0;
        end else if (in_valid && dec.legal) begin
            out_vec <= wide;
            out_rd  <= dec.rd;
        end else begin
            out_vec <= '0;
            out_rd  <= '0;
        end
    end

    always_comb begin
        out_valid   = (state == ST_DONE);
        out_illegal = (state == ST_TRAP);
    end

    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    assert_zero_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_vec == '0 && out_rd == '0));

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid || out_illegal));

    assert_bad_opc_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ((instr & OPC_MASK) != OPC_MATCH)) |=> out_illegal);

    assert_rd_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.legal) |=> (out_rd == $past(instr[4:0])));

endmodule

// File: tb/tb_vwu_unit.sv
`timescale 1ns/100ps
module tb_vwu_unit;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [31:0]   instr;
    logic [VL-1:0] src_vec;
    logic          out_valid, out_illegal;
    logic [4:0]    out_rd;
    logic [VL-1:0] out_vec;

    vwu_unit #(.VL_BITS(VL)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_vec(src_vec), .out_valid(out_valid), .out_illegal(out_illegal),
        .out_rd(out_rd), .out_vec(out_vec)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic          e_valid, e_ill;
    logic [4:0]    e_rd;
    logic [VL-1:0] e_vec;
    string         e_tag;
    bit            have_exp = 0;

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // behavioural model of one issue
    task automatic model(input logic v, input logic [31:0] w, input logic [VL-1:0] s);
        int dw, hw, n, idx;
        logic msb;
        e_valid = 0; e_ill = 0; e_rd = '0; e_vec = '0;
        if (!v) return;
        if ((w & 32'hFF3CFC00) != 32'h05303800 || w[23:22] == 2'b00) begin
            e_ill = 1;
            return;
        end
        e_valid = 1;
        e_rd = w[4:0];
        dw = 8 << w[23:22];
        hw = dw / 2;
        n = VL / dw;
        for (int e = 0; e < n; e++) begin
            idx = w[16] ? e + n : e;
            for (int b = 0; b < hw; b++) e_vec[e*dw + b] = s[idx*hw + b];
            msb = w[17] ? 1'b0 : s[idx*hw + hw - 1];
            for (int b = hw; b < dw; b++) e_vec[e*dw + b] = msb;
        end
    endtask

    task automatic compare();
        n_checks++;
        if (out_valid !== e_valid || out_illegal !== e_ill ||
            out_rd !== e_rd || out_vec !== e_vec) begin
            n_fail++;
            $display("FAIL %s: got v=%b ill=%b rd=%0d vec=%h exp v=%b ill=%b rd=%0d vec=%h",
                     e_tag, out_valid, out_illegal, out_rd, out_vec,
                     e_valid, e_ill, e_rd, e_vec);
        end
    endtask

    // one clock: check the result of the previous issue, then issue the next
    task automatic step(input logic v, input logic [31:0] w,
                        input logic [VL-1:0] s, input string tag);
        @(negedge clk);
        if (have_exp) compare();
        in_valid = v; instr = w; src_vec = s;
        model(v, w, s);
        e_tag = tag;
        have_exp = 1;
    endtask

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] r;
        for (int i = 0; i < VL/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic uns,
                                       input logic hi, input logic [4:0] rn,
                                       input logic [4:0] rd);
        logic [31:0] w;
        w = 32'h05303800;
        w[23:22] = sz; w[17] = uns; w[16] = hi; w[9:5] = rn; w[4:0] = rd;
        return w;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    initial begin : stim
        logic [VL-1:0] pat;
        logic [31:0]   w;
        rst = 1; in_valid = 0; instr = '0; src_vec = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: state after reset with nothing issued
        step(0, '0, '0, "R1");
        step(0, '0, rnd_vec(), "R1 R2");

        // R5 R6 R7 R8: every size / half / sign combination, random data
        for (int rep = 0; rep < 6; rep++)
            for (int sz = 1; sz < 4; sz++)
                for (int m = 0; m < 4; m++)
                    step(1, mk(2'(sz), m[1], m[0], 5'($urandom), 5'($urandom)),
                         rnd_vec(), m[0] ? "R5 R7 R8" : "R5 R6 R8");

        // R8: extreme byte patterns
        for (int p = 0; p < 3; p++) begin
            pat = (p == 0) ? {(VL/8){8'h80}} : (p == 1) ? {(VL/8){8'hFF}}
                : {{(VL/16){8'hFF}}, {(VL/16){8'h7F}}};
            for (int sz = 1; sz < 4; sz++)
                for (int m = 0; m < 4; m++)
                    step(1, mk(2'(sz), m[1], m[0], 5'd3, 5'd31), pat, "R8 R7");
        end

        // R9: same data, varying source-index field, rd passes through
        pat = rnd_vec();
        for (int rn = 0; rn < 32; rn += 7)
            step(1, mk(2'b10, 1'b0, 1'b1, 5'(rn), 5'(rn + 1)), pat, "R9");

        // R3: single fixed opcode bit flipped
        foreach (w[i]) begin
            if (32'hFF3CFC00 & (32'h1 << i)) begin
                w = mk(2'b01, 1'b0, 1'b0, 5'd1, 5'd2) ^ (32'h1 << i);
                step(1, w, rnd_vec(), "R3 R10");
                step(1, mk(2'b11, 1'b1, 1'b0, 5'd4, 5'd9), rnd_vec(), "R3 R5");
            end
        end

        // R4: reserved size between legal words
        for (int m = 0; m < 4; m++) begin
            step(1, mk(2'b00, m[1], m[0], 5'd0, 5'd7), rnd_vec(), "R4 R10");
            step(1, mk(2'b01, m[1], m[0], 5'd0, 5'd7), rnd_vec(), "R4 R5");
        end

        // R2: gaps in issue, and in_valid low with a legal word on the bus
        step(0, mk(2'b01, 1'b0, 1'b0, 5'd1, 5'd1), rnd_vec(), "R2");
        step(1, mk(2'b10, 1'b1, 1'b1, 5'd1, 5'd5), rnd_vec(), "R2");
        step(0, '0, '0, "R2 R10");
        step(0, '0, '0, "R2");

        // R1: reset while a result is held
        step(1, mk(2'b11, 1'b0, 1'b1, 5'd2, 5'd12), {(VL/8){8'h80}}, "R1");
        @(negedge clk);
        compare();
        have_exp = 0;
        rst = 1; in_valid = 0;
        @(negedge clk);
        e_valid = 0; e_ill = 0; e_rd = '0; e_vec = '0; e_tag = "R1";
        compare();
        rst = 0;
        step(0, '0, '0, "R1");
        step(0, '0, '0, "R1");
        summary();
    end

endmodule